// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows the timing of a single DRAM bank from the moment it is opened until it may be opened again, for the case where the bank is closed by a read that carries the auto-precharge flag. A controller reports each accepted activate and each read to the tracker. The tracker then works out the clock edge on which the bank's internal precharge begins. That edge is the latest of three points: the end of the burst (additive latency plus half the burst length), the minimum row-active time counted from the activate, and the read-to-precharge time counted from the read. The tracker counts the row-precharge time from that exact edge and signals when a new activate is legal.

All cycle counts are whole clock cycles. The configuration is captured while reset is held or when a load strobe is pulsed, and it stays fixed between loads. The bank state is visible at the ports as an encoded value. An activate that arrives before the bank is ready is reported on an error output and is otherwise dropped.

Top module: `bank_ap_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, bank_state is 0 (idle), act_ready is 1 and timing_err is 0.
- R2: An activate taken while act_ready is 1 moves bank_state to 1 (open) on that edge. act_ready is 0 while the bank is open.
- R3: A read with rd_autopre low leaves bank_state at 1 for as long as no read with rd_autopre high arrives.
- R4: A read with rd_autopre high on an open bank moves bank_state to 2 (waiting) on its edge k. If tRTP is at most 2 and tRAS has already elapsed, bank_state becomes 3 (precharging) on edge k + AL + BL/2, where BL is 8 when cfg_bl8 is 1 and 4 otherwise.
- R5: If tRTP is above 2, the precharge edge is no earlier than k + AL + BL/2 - 2 + tRTP.
- R6: The precharge edge is no earlier than a + tRAS, where a is the edge on which the activate was taken.
- R7: If the precharge begins on edge p, act_ready is 1 in the cycle that ends with edge p + tRP, so that an activate there is legal. Without that activate, bank_state returns to 0 on that edge. pre_start is 1 exactly in the cycle that ends with edge p.
- R8: An activate presented while act_ready is 0 sets timing_err to 1 for the following cycle and does not open the bank.
- R9: The configuration inputs take effect only while reset is held or when cfg_load is 1. Changing them at other times does not alter the timing.
- R10: A read presented while the bank is idle is ignored: bank_state stays 0 and act_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration |
| cfg_load | input | 1 | Strobe that captures the configuration inputs |
| cfg_al | input | TW | Additive latency in cycles |
| cfg_bl8 | input | 1 | 1 for a burst of 8, 0 for a burst of 4 |
| cfg_tras | input | TW | Minimum row-active time in cycles |
| cfg_trtp | input | TW | Read-to-precharge time in cycles |
| cfg_trp | input | TW | Row-precharge time in cycles |
| cmd_act | input | 1 | Activate command for this bank |
| cmd_rd | input | 1 | Read command for this bank |
| rd_autopre | input | 1 | Auto-precharge flag carried with the read |
| bank_state | output | 2 | 0 idle, 1 open, 2 waiting to precharge, 3 precharging |
| act_ready | output | 1 | An activate on the coming edge is legal |
| pre_start | output | 1 | Internal precharge begins on the coming edge |
| timing_err | output | 1 | An activate arrived too early in the previous cycle |

## Verification
The precharge edge is measured under four settings. In the first, the burst point wins with a burst of 4. In the second, a burst of 8 and a nonzero additive latency make the burst point win. In the third, a long read-to-precharge time decides the edge. In the fourth, the read follows the activate at once under a long row-active time, so the edge must come from the activate and not from the read. Each run also measures the gap from read to ready and to idle, which shows that the precharge interval is counted from the actual precharge edge. Separate runs check that plain reads keep the bank open, that reads to an idle bank and unloaded configuration changes have no effect, and that early activates raise the error and are dropped.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APWAIT = 2'd2,
    BK_PRECH  = 2'd3
  } bank_st_e;

  // Edges from the read to the end of the burst prefetch window.
  function automatic int unsigned burst_point(int unsigned al, logic bl8);
    return al + (bl8 ? 32'd4 : 32'd2);
  endfunction

  // Edges from the read until read-to-precharge is met.
  function automatic int unsigned rtp_point(int unsigned al, logic bl8,
                                            int unsigned trtp);
    return burst_point(al, bl8) - 32'd2 + trtp;
  endfunction

  // Read-derived precharge delay (row-active limit handled separately).
  function automatic int unsigned read_to_pre(int unsigned al, logic bl8,
                                              int unsigned trtp);
    int unsigned b;
    int unsigned r;
    b = burst_point(al, bl8);
    r = rtp_point(al, bl8, trtp);
    return (r > b) ? r : b;
  endfunction

  // Precharge interval, never shorter than one cycle.
  function automatic int unsigned prech_len(int unsigned trp);
    return (trp == 32'd0) ? 32'd1 : trp;
  endfunction

endpackage

// File: rtl/bank_ap_cfg.sv
module bank_ap_cfg #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [TW-1:0] al_i,
  input  logic          bl8_i,
  input  logic [TW-1:0] tras_i,
  input  logic [TW-1:0] trtp_i,
  input  logic [TW-1:0] trp_i,
  output logic [TW-1:0] al_o,
  output logic          bl8_o,
  output logic [TW-1:0] tras_o,
  output logic [TW-1:0] trtp_o,
  output logic [TW-1:0] trp_o
);

  logic capture;
  assign capture = !rst_n || cfg_load;

  always_ff @(posedge clk) begin
    if (capture) begin
      al_o   <= al_i;
      bl8_o  <= bl8_i;
      tras_o <= tras_i;
      trtp_o <= trtp_i;
      trp_o  <= trp_i;
    end
  end

endmodule

// File: rtl/bank_ras_timer.sv
module bank_ras_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_go,
  input  logic [TW-1:0] tras,
  output logic          ras_ok
);

  localparam int RW = TW + 1;

  logic [RW-1:0] since_act_q;

  // Holds the number of edges since the activate, as seen before the next edge.
  always_ff @(posedge clk) begin
    if (!rst_n)
      since_act_q <= '0;
    else if (act_go)
      since_act_q <= RW'(1);
    else if (since_act_q != '1)
      since_act_q <= since_act_q + RW'(1);
  end

  assign ras_ok = since_act_q >= {1'b0, tras};

endmodule

// File: rtl/bank_ap_fsm.sv
module bank_ap_fsm
  import bank_ap_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_go,
  input  logic          rd_go,
  input  logic          rd_ap,
  input  logic          ras_ok,
  input  logic [TW-1:0] al,
  input  logic          bl8,
  input  logic [TW-1:0] trtp,
  input  logic [TW-1:0] trp,
  output bank_st_e      state_o,
  output logic          ready_o,
  output logic          pre_start_o
);

  localparam int CW = TW + 3;

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ap_len, rp_len;
  logic          cnt_zero;

  assign ap_len   = CW'(read_to_pre(32'(al), bl8, 32'(trtp)) - 32'd1);
  assign rp_len   = CW'(prech_len(32'(trp)) - 32'd1);
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    pre_start_o = 1'b0;
    case (st_q)
      BK_IDLE: begin
        if (act_go) st_d = BK_OPEN;
      end
      BK_OPEN: begin
        if (rd_go && rd_ap) begin
          st_d  = BK_APWAIT;
          cnt_d = ap_len;
        end
      end
      BK_APWAIT: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CW'(1);
        end else if (ras_ok) begin
          pre_start_o = 1'b1;
          st_d        = BK_PRECH;
          cnt_d       = rp_len;
        end
      end
      BK_PRECH: begin
        if (!cnt_zero) cnt_d = cnt_q - CW'(1);
        else           st_d  = act_go ? BK_OPEN : BK_IDLE;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign ready_o = (st_q == BK_IDLE) || ((st_q == BK_PRECH) && cnt_zero);

endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
  import bank_ap_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [TW-1:0] cfg_al,
  input  logic          cfg_bl8,
  input  logic [TW-1:0] cfg_tras,
  input  logic [TW-1:0] cfg_trtp,
  input  logic [TW-1:0] cfg_trp,
  input  logic          cmd_act,
  input  logic          cmd_rd,
  input  logic          rd_autopre,
  output logic [1:0]    bank_state,
  output logic          act_ready,
  output logic          pre_start,
  output logic          timing_err
);

  logic [TW-1:0] al_q, tras_q, trtp_q, trp_q;
  logic          bl8_q;
  logic          act_go;
  logic          ras_ok;
  bank_st_e      st;

  bank_ap_cfg #(.TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .al_i(cfg_al), .bl8_i(cfg_bl8), .tras_i(cfg_tras),
    .trtp_i(cfg_trtp), .trp_i(cfg_trp),
    .al_o(al_q), .bl8_o(bl8_q), .tras_o(tras_q),
    .trtp_o(trtp_q), .trp_o(trp_q)
  );

  bank_ras_timer #(.TW(TW)) u_ras (
    .clk(clk), .rst_n(rst_n), .act_go(act_go),
    .tras(tras_q), .ras_ok(ras_ok)
  );

  bank_ap_fsm #(.TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .act_go(act_go),
    .rd_go(cmd_rd), .rd_ap(rd_autopre), .ras_ok(ras_ok),
    .al(al_q), .bl8(bl8_q), .trtp(trtp_q), .trp(trp_q),
    .state_o(st), .ready_o(act_ready), .pre_start_o(pre_start)
  );

  assign act_go     = cmd_act && act_ready;
  assign bank_state = st;

  always_ff @(posedge clk) begin
    if (!rst_n) timing_err <= 1'b0;
    else        timing_err <= cmd_act && !act_ready;
  end

endmodule

// File: rtl/bank_ap_chk.sv
module bank_ap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_act,
  input logic       cmd_rd,
  input logic       rd_autopre,
  input logic [1:0] bank_state,
  input logic       act_ready,
  input logic       pre_start,
  input logic       timing_err,
  input logic       act_go,
  input logic       ras_ok
);

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == 2'd0) |-> act_ready);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (bank_state == 2'd1));

  p_open_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == 2'd1) |-> !act_ready);

  p_plain_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_state == 2'd1) && !(cmd_rd && rd_autopre)) |=> (bank_state == 2'd1));

  p_pre_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |=> (bank_state == 2'd3));

  p_pre_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_start |-> ras_ok);

  p_prech_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == 2'd3) |=> (bank_state != 2'd2));

  p_early_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act && !act_ready) |=> timing_err);

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_state == 2'd0) && !cmd_act) |=> (bank_state == 2'd0));

endmodule

bind bank_ap_tracker bank_ap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
  .rd_autopre(rd_autopre), .bank_state(bank_state), .act_ready(act_ready),
  .pre_start(pre_start), .timing_err(timing_err),
  .act_go(act_go), .ras_ok(ras_ok)
);

// File: tb/tb_bank_ap_tracker.sv
module tb_bank_ap_tracker;

  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [TW-1:0] cfg_al = '0, cfg_tras = 6'd3, cfg_trtp = 6'd2, cfg_trp = 6'd3;
  logic          cfg_bl8 = 1'b0;
  logic          cmd_act = 1'b0, cmd_rd = 1'b0, rd_autopre = 1'b0;
  logic [1:0]    bank_state;
  logic          act_ready, pre_start, timing_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int c_al = 0, c_bl = 4, c_tras = 3, c_trtp = 2, c_trp = 3;

  always #4 clk = ~clk;

  bank_ap_tracker #(.TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_al(cfg_al), .cfg_bl8(cfg_bl8), .cfg_tras(cfg_tras),
    .cfg_trtp(cfg_trtp), .cfg_trp(cfg_trp),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .rd_autopre(rd_autopre),
    .bank_state(bank_state), .act_ready(act_ready),
    .pre_start(pre_start), .timing_err(timing_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(int al, int bl, int tras, int trtp, int trp);
    @(negedge clk);
    cfg_al = TW'(al); cfg_bl8 = (bl == 8); cfg_tras = TW'(tras);
    cfg_trtp = TW'(trtp); cfg_trp = TW'(trp); cfg_load = 1'b1;
    c_al = al; c_bl = bl; c_tras = tras; c_trtp = trtp; c_trp = trp;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic open_bank(string req);
    cmd_act = 1'b1;
    @(negedge clk);
    cmd_act = 1'b0;
    chk({req, " state after activate"}, bank_state, 1);
    chk({req, " ready while open"}, act_ready, 0);
  endtask

  // Read with auto-precharge and measurement of the precharge and ready edges.
  task automatic ap_read(int w, string req);
    int e_pre, e_gap, ras_idx;
    int pre_idx = -1, ps_idx = -1, rdy_idx = -1, idle_idx = -1;
    e_pre = c_al + c_bl / 2;
    if (c_trtp > 2) e_pre = e_pre + c_trtp - 2;
    ras_idx = c_tras - 1 - w;
    if (ras_idx > e_pre) e_pre = ras_idx;
    e_gap = e_pre + c_trp;
    cmd_rd = 1'b1; rd_autopre = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0; rd_autopre = 1'b0;
    chk({req, " waiting state after read"}, bank_state, 2);
    for (int i = 1; i < 300; i++) begin
      if (ps_idx < 0 && pre_start) ps_idx = i - 1;
      @(negedge clk);
      if (pre_idx < 0 && bank_state == 2'd3) pre_idx = i;
      if (rdy_idx < 0 && act_ready) rdy_idx = i;
      if (bank_state == 2'd0) begin idle_idx = i; break; end
    end
    chk({req, " precharge edge"}, pre_idx, e_pre);
    chk({req, " pre_start cycle"}, ps_idx, e_pre - 1);
    chk({req, " R7 ready cycle"}, rdy_idx, e_gap - 1);
    chk({req, " R7 idle edge"}, idle_idx, e_gap);
  endtask

  task automatic t_reset();
    chk("R1 state in reset", bank_state, 0);
    chk("R1 ready in reset", act_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", bank_state, 0);
    chk("R1 ready after reset", act_ready, 1);
    chk("R1 err after reset", timing_err, 0);
  endtask

  task automatic t_burst4();
    apply_cfg(0, 4, 3, 2, 3);
    open_bank("R2");
    repeat (5) @(negedge clk);
    ap_read(5, "R4 burst4");
  endtask

  task automatic t_burst8_al();
    apply_cfg(2, 8, 3, 2, 4);
    open_bank("R2");
    repeat (5) @(negedge clk);
    ap_read(5, "R4 R9 burst8 al2");
  endtask

  task automatic t_rtp();
    apply_cfg(1, 4, 3, 5, 2);
    open_bank("R2");
    repeat (5) @(negedge clk);
    ap_read(5, "R5 rtp push");
  endtask

  task automatic t_ras();
    apply_cfg(0, 8, 20, 2, 3);
    open_bank("R2");
    ap_read(0, "R6 ras push");
  endtask

  task automatic t_plain_read();
    apply_cfg(0, 4, 3, 2, 3);
    open_bank("R2");
    cmd_rd = 1'b1; rd_autopre = 1'b0;
    @(negedge clk);
    cmd_rd = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk("R3 open after plain read", bank_state, 1);
      @(negedge clk);
    end
    ap_read(9, "R3 close after plain reads");
  endtask

  task automatic t_early_act();
    apply_cfg(0, 4, 3, 2, 3);
    open_bank("R2");
    cmd_act = 1'b1;
    @(negedge clk);
    cmd_act = 1'b0;
    chk("R8 err on act while open", timing_err, 1);
    chk("R8 still open", bank_state, 1);
    repeat (3) @(negedge clk);
    cmd_rd = 1'b1; rd_autopre = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0; rd_autopre = 1'b0;
    cmd_act = 1'b1;
    @(negedge clk);
    cmd_act = 1'b0;
    chk("R8 err on act while waiting", timing_err, 1);
    chk("R8 bank not reopened", bank_state, 2);
    @(negedge clk);
    chk("R8 err clears", timing_err, 0);
    for (int i = 0; i < 50 && bank_state != 2'd0; i++) @(negedge clk);
    open_bank("R8 legal act after idle");
    chk("R8 no err on legal act", timing_err, 0);
    repeat (4) @(negedge clk);
    ap_read(4, "R8 close");
  endtask

  task automatic t_idle_read();
    cmd_rd = 1'b1; rd_autopre = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0; rd_autopre = 1'b0;
    chk("R10 idle after read", bank_state, 0);
    chk("R10 ready after read", act_ready, 1);
    @(negedge clk);
    chk("R10 still idle", bank_state, 0);
  endtask

  task automatic t_cfg_hold();
    apply_cfg(0, 4, 3, 2, 3);
    cfg_al = 6'd5; cfg_trp = 6'd9; cfg_trtp = 6'd7; cfg_bl8 = 1'b1;
    open_bank("R2");
    repeat (5) @(negedge clk);
    ap_read(5, "R9 unloaded cfg ignored");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_burst4();
    t_burst8_al();
    t_rtp();
    t_ras();
    t_plain_read();
    t_early_act();
    t_idle_read();
    t_cfg_hold();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule